// File: doc/BRIEF.md
# Cascadable Maskable Interrupt Controller

This block gathers eight interrupt request lines from peripherals and raises one interrupt output toward a CPU. Each line has its own mask bit. A request is latched as pending and stays pending until the CPU takes it, even if its line is masked when it arrives. When the CPU acknowledges, the block picks the winning line, moves that line from pending to in-service, and returns a vector number over a one-cycle result strobe. The CPU finishes handling by writing an end-of-interrupt command. The command can retire the most urgent line in service, or a line that the command names.

The CPU reaches the block through a small register port with one select bit. With select 1, a write sets the mask and a read returns it. With select 0, a write issues a command and a read returns the in-service bits. Two instances can be chained. The master's input at the cascade line takes the slave's interrupt output. When that line wins an acknowledge, the master passes the acknowledge on to the slave through its cascade output and stays silent. The slave then returns a vector from its own base. This gives fifteen usable lines.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF (all lines disabled), no line is pending or in service, and the interrupt output is low.
- R2: A write with select 1 loads the 8-bit mask, in which a 1 bit disables its line. A read with select 1 returns the mask, and select 0 returns the in-service bits. Writing 0xFD leaves only line 1 enabled.
- R3: A request seen on any line, masked or not, is held as pending until acknowledged. A masked pending request raises the interrupt once its mask bit is cleared, even if the line has already dropped.
- R4: Priority is fixed, with line 0 highest. The interrupt output is high only when an unmasked pending line has a lower index than every line in service.
- R5: On an acknowledge while the interrupt output is high, the winning line leaves pending and enters in-service. On the following cycle the vector strobe is high for exactly one cycle, with vector base + line index (base 8 gives vector 9 for line 1).
- R6: Command 0x20 clears the in-service bit of the lowest-indexed (highest-priority) line in service.
- R7: Command 0x60 + n, for n from 0 to 7, clears the in-service bit of line n only.
- R8: A command value other than 0x20 or 0x60 to 0x67 leaves every register unchanged.
- R9: With cascading enabled, an acknowledge won by the cascade line sets that line in service and gives no master vector. The same cycle it raises the cascade output, and the slave driven by that output returns its own base + its winning line.
- R10: An acknowledge while the interrupt output is low changes no state and returns the vector base + 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irqIn | input | 8 | Interrupt request lines, line 0 highest priority |
| regWr | input | 1 | Register write strobe |
| regSel | input | 1 | 1 selects the mask, 0 selects command write / in-service read |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data (mask or in-service, by regSel) |
| intAck | input | 1 | Acknowledge from the CPU or from a master's cascade output |
| intReq | output | 1 | Interrupt output to the CPU or to a master input |
| vecValid | output | 1 | One-cycle strobe marking a vector |
| vecNum | output | 8 | Vector number |
| cascadeAck | output | 1 | Acknowledge passed on to a slave |

## Verification
The bench builds two instances. The master uses base 8 with cascading on line 2. The slave uses base 0x70 with cascading off, and its interrupt output feeds the master's line 2. This puts single-line delivery, nesting by priority, both kinds of end-of-interrupt and the spurious vector within reach on the master alone. The chained pair adds the routed acknowledge, a slave vector from its own base, and a check that the two vector strobes never overlap.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LINES = 8;
  localparam int IDXW  = $clog2(LINES);

  // Strobes from control to the register datapath
  typedef struct packed {
    logic             maskWr;
    logic [LINES-1:0] maskData;
    logic [LINES-1:0] ackSet;
    logic [LINES-1:0] isClear;
  } dpStrobe_t;
endpackage

// File: rtl/prio_irq_dp.sv
module prio_irq_dp
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] irqIn,
  input  dpStrobe_t        strobe,
  output logic [LINES-1:0] pendReg,
  output logic [LINES-1:0] maskReg,
  output logic [LINES-1:0] isReg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      maskReg <= '1;
      pendReg <= '0;
      isReg   <= '0;
    end else begin
      if (strobe.maskWr) maskReg <= strobe.maskData;
      pendReg <= (pendReg | irqIn) & ~strobe.ackSet;
      isReg   <= (isReg | strobe.ackSet) & ~strobe.isClear;
    end
  end

  // R1: state right after reset
  assert_mask_reset_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> (maskReg == '1 && pendReg == '0 && isReg == '0));

  // R3: a pending bit only drops when that line is acknowledged
  assert_pend_kept_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pendReg) & ~pendReg & ~$past(strobe.ackSet)) == '0));

  // R5: an acknowledged line is in service on the next cycle
  assert_ack_in_service_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(strobe.ackSet) & ~$past(strobe.isClear) & ~isReg) == '0));

endmodule

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
  import prio_irq_pkg::*;
#(
  parameter int VEC_BASE     = 8,
  parameter bit CASCADE_EN   = 1'b0,
  parameter int CASCADE_LINE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] pendReg,
  input  logic [LINES-1:0] maskReg,
  input  logic [LINES-1:0] isReg,
  input  logic             intAck,
  input  logic             regWr,
  input  logic             regSel,
  input  logic [7:0]       regWrData,
  output dpStrobe_t        strobe,
  output logic             intReq,
  output logic             cascadeAck,
  output logic             vecValid,
  output logic [7:0]       vecNum
);

  localparam logic [IDXW:0]    NONE     = (IDXW+1)'(LINES);
  localparam logic [LINES-1:0] ONE      = LINES'(1);
  localparam logic [7:0]       CMD_NS   = 8'h20;
  localparam logic [7:0]       CMD_SP   = 8'h60;
  localparam logic [7:0]       SP_MASK  = ~8'(LINES - 1);
  localparam logic [IDXW:0]    CAS_IDX  = (IDXW+1)'(CASCADE_LINE);

  function automatic logic [IDXW:0] lowestSet(input logic [LINES-1:0] v);
    lowestSet = NONE;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) lowestSet = (IDXW+1)'(i);
  endfunction

  logic [IDXW:0] winIdx, isIdx;
  logic          ackGo, toSlave, cmdWr, nsEoi, spEoi;

  assign winIdx = lowestSet(pendReg & ~maskReg);
  assign isIdx  = lowestSet(isReg);
  assign intReq = (winIdx != NONE) && (winIdx < isIdx);
  assign ackGo  = intAck && intReq;

  generate
    if (CASCADE_EN) begin : g_cas
      assign toSlave = ackGo && (winIdx == CAS_IDX);
    end else begin : g_nocas
      assign toSlave = 1'b0;
    end
  endgenerate
  assign cascadeAck = toSlave;

  assign cmdWr = regWr && !regSel;
  assign nsEoi = cmdWr && (regWrData == CMD_NS);
  assign spEoi = cmdWr && ((regWrData & SP_MASK) == CMD_SP);

  always_comb begin
    strobe          = '0;
    strobe.maskWr   = regWr && regSel;
    strobe.maskData = regWrData[LINES-1:0];
    if (ackGo) strobe.ackSet = ONE << winIdx[IDXW-1:0];
    if (nsEoi && isIdx != NONE) strobe.isClear = ONE << isIdx[IDXW-1:0];
    if (spEoi) strobe.isClear = ONE << regWrData[IDXW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vecValid <= 1'b0;
      vecNum   <= '0;
    end else begin
      vecValid <= intAck && !toSlave;
      vecNum   <= ackGo ? 8'(VEC_BASE + int'(winIdx))
                        : 8'(VEC_BASE + LINES - 1);
    end
  end

  // R5: a vector only follows an acknowledge
  assert_vec_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
    vecValid |-> $past(intAck));

  // R4: the interrupt only stands for a line that is pending, unmasked and not in service
  assert_int_eligible_R4: assert property (@(posedge clk) disable iff (rst)
    intReq |-> ((pendReg & ~maskReg & ~isReg) != '0));

  // R9: a routed acknowledge leaves this instance silent on the vector strobe
  assert_cascade_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    cascadeAck |=> !vecValid);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int VEC_BASE     = 8,
  parameter bit CASCADE_EN   = 1'b0,
  parameter int CASCADE_LINE = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] irqIn,
  input  logic       regWr,
  input  logic       regSel,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       intAck,
  output logic       intReq,
  output logic       vecValid,
  output logic [7:0] vecNum,
  output logic       cascadeAck
);

  dpStrobe_t        strobe;
  logic [LINES-1:0] pendReg, maskReg, isReg;

  prio_irq_dp i_dp (
    .clk(clk), .rst(rst), .irqIn(irqIn[LINES-1:0]), .strobe(strobe),
    .pendReg(pendReg), .maskReg(maskReg), .isReg(isReg)
  );

  prio_irq_ctl #(
    .VEC_BASE(VEC_BASE), .CASCADE_EN(CASCADE_EN), .CASCADE_LINE(CASCADE_LINE)
  ) i_ctl (
    .clk(clk), .rst(rst), .pendReg(pendReg), .maskReg(maskReg), .isReg(isReg),
    .intAck(intAck), .regWr(regWr), .regSel(regSel), .regWrData(regWrData),
    .strobe(strobe), .intReq(intReq), .cascadeAck(cascadeAck),
    .vecValid(vecValid), .vecNum(vecNum)
  );

  assign regRdData = 8'(regSel ? maskReg : isReg);

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [7:0] mReq = '0, sReq = '0;
  logic mWr = 0, mSel = 0, sWr = 0, sSel = 0, mAck = 0;
  logic [7:0] mData = '0, sData = '0;
  logic [7:0] mRd, sRd, mVec, sVec;
  logic mInt, sInt, mVV, sVV, mCas, sCas;

  prio_irq_ctrl #(.VEC_BASE(8), .CASCADE_EN(1'b1), .CASCADE_LINE(2)) i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irqIn({mReq[7:3], sInt, mReq[1:0]}),
    .regWr(mWr), .regSel(mSel), .regWrData(mData), .regRdData(mRd),
    .intAck(mAck), .intReq(mInt), .vecValid(mVV), .vecNum(mVec), .cascadeAck(mCas));

  prio_irq_ctrl #(.VEC_BASE(8'h70), .CASCADE_EN(1'b0), .CASCADE_LINE(2)) i_slave (
    .clk(clk), .rst(rst), .irqIn(sReq),
    .regWr(sWr), .regSel(sSel), .regWrData(sData), .regRdData(sRd),
    .intAck(mCas), .intReq(sInt), .vecValid(sVV), .vecNum(sVec), .cascadeAck(sCas));

  int checks = 0, errors = 0;
  int expQ[$];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input bit slave, input bit sel, input logic [7:0] d);
    @(negedge clk);
    if (slave) begin sWr = 1; sSel = sel; sData = d; end
    else begin mWr = 1; mSel = sel; mData = d; end
    @(negedge clk);
    mWr = 0; sWr = 0;
  endtask

  task automatic regRead(input bit slave, input bit sel, output logic [7:0] d);
    if (slave) sSel = sel; else mSel = sel;
    #1;
    d = slave ? sRd : mRd;
  endtask

  task automatic pulseLine(input bit slave, input int n);
    @(negedge clk);
    if (slave) sReq[n] = 1'b1; else mReq[n] = 1'b1;
    @(negedge clk);
    sReq = '0; mReq = '0;
  endtask

  // driver: queue the expected vector, then acknowledge for one cycle
  task automatic ackCpu(input int expVec);
    expQ.push_back(expVec);
    @(negedge clk); mAck = 1'b1;
    @(negedge clk); mAck = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pop and compare every vector strobe
  always @(negedge clk) begin
    if (!rst) begin
      if (mVV && sVV) check("R9 overlapping vector strobes", 1, 0);
      else if (mVV || sVV) begin
        if (expQ.size() == 0) check("R5 unexpected vector", mVV ? mVec : sVec, -1);
        else check("R5 vector", mVV ? mVec : sVec, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    regRead(0, 1, d); check("R1 mask reset", d, 8'hFF);
    regRead(0, 0, d); check("R1 in-service reset", d, 0);
    check("R1 int low", mInt, 0);

    // R3: masked request is held
    pulseLine(0, 1);
    @(negedge clk);
    check("R3 masked no int", mInt, 0);
    regWrite(0, 1, 8'hFD);
    regRead(0, 1, d); check("R2 mask readback", d, 8'hFD);
    check("R3 delivered after unmask", mInt, 1);
    ackCpu(9);
    regRead(0, 0, d); check("R5 in-service line1", d, 8'h02);
    check("R5 int dropped", mInt, 0);
    regWrite(0, 0, 8'h20);
    regRead(0, 0, d); check("R6 eoi clears", d, 0);

    // R4: priority and nesting
    regWrite(0, 1, 8'h00);
    pulseLine(0, 5);
    pulseLine(0, 3);
    ackCpu(11);
    regRead(0, 0, d); check("R4 line3 first", d, 8'h08);
    check("R4 line5 blocked by line3", mInt, 0);
    pulseLine(0, 0);
    check("R4 line0 preempts", mInt, 1);
    ackCpu(8);
    regRead(0, 0, d); check("R4 nested in-service", d, 8'h09);
    regWrite(0, 0, 8'h20);
    regRead(0, 0, d); check("R6 clears highest only", d, 8'h08);
    check("R4 still blocked", mInt, 0);
    regWrite(0, 0, 8'h13);
    regRead(0, 0, d); check("R8 unknown command ignored", d, 8'h08);
    regRead(0, 1, d); check("R8 mask untouched", d, 8'h00);
    regWrite(0, 0, 8'h63);
    regRead(0, 0, d); check("R7 specific eoi line3", d, 0);
    check("R7 line5 now raises", mInt, 1);
    ackCpu(13);
    regWrite(0, 0, 8'h65);
    regRead(0, 0, d); check("R7 specific eoi line5", d, 0);

    // R10: spurious acknowledge
    check("R10 int low before", mInt, 0);
    ackCpu(15);
    regRead(0, 0, d); check("R10 no state change", d, 0);

    // R9: cascade through slave
    regWrite(1, 1, 8'h00);
    pulseLine(1, 4);
    @(negedge clk);
    check("R9 slave raises master", mInt, 1);
    ackCpu(8'h74);
    regRead(0, 0, d); check("R9 master cascade in service", d, 8'h04);
    regRead(1, 0, d); check("R9 slave line4 in service", d, 8'h10);
    regWrite(1, 0, 8'h20);
    regWrite(0, 0, 8'h20);
    regRead(0, 0, d); check("R6 master eoi after cascade", d, 0);
    check("R9 no int left", mInt, 0);

    repeat (3) @(negedge clk);
    check("R5 all vectors seen", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule